// File: doc/BRIEF.md
# ECG Sample FIFO Burst Reader

This block drains a sample FIFO that sits behind a byte-oriented serial transfer engine. After a start pulse it requests the configured number of 24-bit words. It splits the request into bounded transfers and drops the filler byte that leads every transfer. It rebuilds each word most-significant byte first and streams out the valid words, with their two tag fields broken out beside them.

When any word in the burst carries a pace tag other than "none", the block follows the sample transfers with exactly one sweep over the six pace-event groups. Each group read has its own address and returns three words. The block streams out these 18 words with a running index. A single-cycle done pulse closes the burst. While a burst is running, the block ignores any new start request.

The transfer engine gets a command byte and a byte count with a one-cycle request. It then returns that many bytes, one for each cycle in which the valid strobe is high.

Top module: `ecg_burst_reader`

## Requirements
- R1: Every transfer request carries a read command byte formed as the 7-bit address shifted left by one with bit 0 set. Sample transfers use the sample FIFO address.
- R2: A burst reads fitCount+1 words of 3 bytes each. The first data byte received becomes sampleWord[23:16] and the third becomes sampleWord[7:0].
- R3: Sample transfers carry at most CHUNK_BYTES (30) data bytes each. A longer burst is issued as several transfers in sequence, each with its own command. Each requested count is the data byte count plus one.
- R4: The first byte returned by every transfer, sample or pace, is discarded and never enters a word.
- R5: sampleDataTag equals bits 5:3 of a word's low byte, and samplePaceTag equals bits 2:0 of that byte.
- R6: A word whose data tag is 3'b110 (empty) is not delivered on the sample stream. Other words are delivered in FIFO order.
- R7: If any word of the burst has a pace tag other than 3'b111, then after the last sample transfer the six pace groups are read, in order 0 to 5. This happens only once per burst. Group g uses address PACE_ADDR0 + g*PACE_STEP, and each group transfer requests 10 bytes.
- R8: The pace stream delivers 18 words, each rebuilt most-significant byte first. paceIndex runs from 0 to 17, and group g supplies indices 3g to 3g+2.
- R9: If every pace tag of the burst is 3'b111, no pace transfer is issued.
- R10: done is high for exactly one cycle per burst, in the cycle after the final byte is accepted. A start pulse that arrives during a burst has no effect.
- R11: After reset, txStart, done, sampleValid and paceValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a burst (accepted only when idle) |
| fitCount | input | FIT_W | Threshold field; words read = fitCount+1 |
| txStart | output | 1 | One-cycle transfer request |
| txCmd | output | 8 | Read command byte for the request |
| txCount | output | CNT_W | Bytes to return, filler byte included |
| rxValid | input | 1 | Received byte strobe |
| rxByte | input | 8 | Received byte |
| sampleValid | output | 1 | Sample word valid |
| sampleWord | output | 24 | Rebuilt sample word |
| sampleDataTag | output | 3 | Data tag of the sample word |
| samplePaceTag | output | 3 | Pace tag of the sample word |
| paceValid | output | 1 | Pace word valid |
| paceWord | output | 24 | Rebuilt pace word |
| paceIndex | output | PIDX_W | Position 0..17 of the pace word |
| done | output | 1 | Burst complete pulse |

## Verification
The bench sweeps every threshold value from 0 to 31 under three tag patterns. Across that range, bursts of one, two, three and four transfers split at the 30-byte boundary. The first pattern has no pace events and no empty words, so it shows that pace transfers stay off. The second puts a pace event only on the final word, which exposes a late decision to start the pace sweep. The third has many pace events and many empty words, which shows that the sweep still runs only once and that empty words are dropped on their own. The engine inserts idle gaps between bytes and sends a distinctive filler byte, and a second start is pulsed mid-burst every time.

// File: rtl/ecg_burst_pkg.sv
package ecg_burst_pkg;
  localparam int WORD_BYTES  = 3;
  localparam int PACE_GROUPS = 6;
  localparam int PACE_WORDS  = 3;
  localparam logic [2:0] DTAG_EMPTY = 3'b110;
  localparam logic [2:0] PTAG_NONE  = 3'b111;

  typedef struct packed {
    logic clearAsm;
    logic pushSample;
    logic pushPace;
  } dpStrobeT;

  function automatic logic [7:0] mkReadCmd(input logic [6:0] addr);
    return {addr, 1'b1};
  endfunction
endpackage

// File: rtl/ecg_burst_dp.sv
module ecg_burst_dp
  import ecg_burst_pkg::*;
#(
  parameter int PIDX_W = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [7:0]        rxByte,
  output logic              paceHit,
  output logic              sampleValid,
  output logic [23:0]       sampleWord,
  output logic [2:0]        sampleDataTag,
  output logic [2:0]        samplePaceTag,
  output logic              paceValid,
  output logic [23:0]       paceWord,
  output logic [PIDX_W-1:0] paceIndex
);
  logic [1:0]        phase;
  logic [15:0]       hold;
  logic [PIDX_W-1:0] paceCnt;
  logic              pushAny;
  logic              wordEnd;

  always_comb begin
    pushAny = strobe.pushSample | strobe.pushPace;
    wordEnd = pushAny && (phase == 2'(WORD_BYTES - 1));
    paceHit = strobe.pushSample && wordEnd && (rxByte[2:0] != PTAG_NONE);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase         <= '0;
      hold          <= '0;
      paceCnt       <= '0;
      sampleValid   <= 1'b0;
      sampleWord    <= '0;
      sampleDataTag <= '0;
      samplePaceTag <= '0;
      paceValid     <= 1'b0;
      paceWord      <= '0;
      paceIndex     <= '0;
    end else begin
      sampleValid <= 1'b0;
      paceValid   <= 1'b0;
      if (strobe.clearAsm) begin
        phase   <= '0;
        paceCnt <= '0;
      end else if (pushAny) begin
        if (wordEnd) begin
          phase <= '0;
          if (strobe.pushSample) begin
            sampleValid   <= (rxByte[5:3] != DTAG_EMPTY);
            sampleWord    <= {hold, rxByte};
            sampleDataTag <= rxByte[5:3];
            samplePaceTag <= rxByte[2:0];
          end else begin
            paceValid <= 1'b1;
            paceWord  <= {hold, rxByte};
            paceIndex <= paceCnt;
            paceCnt   <= paceCnt + 1'b1;
          end
        end else begin
          phase <= phase + 2'd1;
          hold  <= {hold[7:0], rxByte};
        end
      end
    end
  end
endmodule

// File: rtl/ecg_burst_ctrl.sv
module ecg_burst_ctrl
  import ecg_burst_pkg::*;
#(
  parameter int         FIT_W       = 5,
  parameter int         CHUNK_BYTES = 30,
  parameter logic [6:0] ECG_ADDR    = 7'h20,
  parameter logic [6:0] PACE_ADDR0  = 7'h30,
  parameter int         PACE_STEP   = 2,
  parameter int         BYTE_W      = 7,
  parameter int         CNT_W       = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [FIT_W-1:0] fitCount,
  input  logic             rxValid,
  input  logic             paceHit,
  output logic             txStart,
  output logic [7:0]       txCmd,
  output logic [CNT_W-1:0] txCount,
  output logic             done,
  output dpStrobeT         strobe
);
  typedef enum logic [2:0] {
    S_IDLE, S_ECG_CMD, S_ECG_RX, S_PACE_CMD, S_PACE_RX, S_FINISH
  } stateT;

  stateT             state;
  logic [BYTE_W-1:0] remBytes;
  logic [BYTE_W-1:0] chunkData;
  logic [CNT_W-1:0]  chunkLeft;
  logic              firstByte;
  logic              paceSeen;
  logic [2:0]        grp;
  logic              lastByte;

  always_comb begin
    chunkData = (remBytes > BYTE_W'(CHUNK_BYTES)) ? BYTE_W'(CHUNK_BYTES) : remBytes;
    lastByte  = rxValid && (chunkLeft == CNT_W'(1));
    txStart   = (state == S_ECG_CMD) || (state == S_PACE_CMD);
    done      = (state == S_FINISH);
    case (state)
      S_ECG_CMD: begin
        txCmd   = mkReadCmd(ECG_ADDR);
        txCount = CNT_W'(chunkData) + CNT_W'(1);
      end
      S_PACE_CMD: begin
        txCmd   = mkReadCmd(7'(int'(PACE_ADDR0) + int'(grp) * PACE_STEP));
        txCount = CNT_W'(PACE_WORDS * WORD_BYTES + 1);
      end
      default: begin
        txCmd   = '0;
        txCount = '0;
      end
    endcase
    strobe.clearAsm   = (state == S_IDLE) && start;
    strobe.pushSample = (state == S_ECG_RX) && rxValid && !firstByte;
    strobe.pushPace   = (state == S_PACE_RX) && rxValid && !firstByte;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      remBytes  <= '0;
      chunkLeft <= '0;
      firstByte <= 1'b0;
      paceSeen  <= 1'b0;
      grp       <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          remBytes <= BYTE_W'((int'(fitCount) + 1) * WORD_BYTES);
          paceSeen <= 1'b0;
          grp      <= '0;
          state    <= S_ECG_CMD;
        end
        S_ECG_CMD: begin
          remBytes  <= remBytes - chunkData;
          chunkLeft <= txCount;
          firstByte <= 1'b1;
          state     <= S_ECG_RX;
        end
        S_ECG_RX: if (rxValid) begin
          firstByte <= 1'b0;
          chunkLeft <= chunkLeft - 1'b1;
          if (paceHit) paceSeen <= 1'b1;
          if (lastByte) begin
            if (remBytes != '0)          state <= S_ECG_CMD;
            else if (paceSeen || paceHit) state <= S_PACE_CMD;
            else                          state <= S_FINISH;
          end
        end
        S_PACE_CMD: begin
          chunkLeft <= txCount;
          firstByte <= 1'b1;
          state     <= S_PACE_RX;
        end
        S_PACE_RX: if (rxValid) begin
          firstByte <= 1'b0;
          chunkLeft <= chunkLeft - 1'b1;
          if (lastByte) begin
            if (grp == 3'(PACE_GROUPS - 1)) state <= S_FINISH;
            else begin
              grp   <= grp + 3'd1;
              state <= S_PACE_CMD;
            end
          end
        end
        default: state <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ecg_burst_reader.sv
module ecg_burst_reader
  import ecg_burst_pkg::*;
#(
  parameter int         FIT_W       = 5,
  parameter int         CHUNK_BYTES = 30,
  parameter logic [6:0] ECG_ADDR    = 7'h20,
  parameter logic [6:0] PACE_ADDR0  = 7'h30,
  parameter int         PACE_STEP   = 2,
  localparam int        BYTE_W      = $clog2(WORD_BYTES * (1 << FIT_W) + 1),
  localparam int        CNT_W       = $clog2(CHUNK_BYTES + 2),
  localparam int        PIDX_W      = $clog2(PACE_GROUPS * PACE_WORDS)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic [FIT_W-1:0]  fitCount,
  output logic              txStart,
  output logic [7:0]        txCmd,
  output logic [CNT_W-1:0]  txCount,
  input  logic              rxValid,
  input  logic [7:0]        rxByte,
  output logic              sampleValid,
  output logic [23:0]       sampleWord,
  output logic [2:0]        sampleDataTag,
  output logic [2:0]        samplePaceTag,
  output logic              paceValid,
  output logic [23:0]       paceWord,
  output logic [PIDX_W-1:0] paceIndex,
  output logic              done
);
  dpStrobeT strobe;
  logic     paceHit;

  ecg_burst_ctrl #(
    .FIT_W(FIT_W), .CHUNK_BYTES(CHUNK_BYTES), .ECG_ADDR(ECG_ADDR),
    .PACE_ADDR0(PACE_ADDR0), .PACE_STEP(PACE_STEP),
    .BYTE_W(BYTE_W), .CNT_W(CNT_W)
  ) ctrlI (
    .clk(clk), .rstN(rstN), .start(start), .fitCount(fitCount),
    .rxValid(rxValid), .paceHit(paceHit), .txStart(txStart),
    .txCmd(txCmd), .txCount(txCount), .done(done), .strobe(strobe)
  );

  ecg_burst_dp #(.PIDX_W(PIDX_W)) dpI (
    .clk(clk), .rstN(rstN), .strobe(strobe), .rxByte(rxByte),
    .paceHit(paceHit), .sampleValid(sampleValid), .sampleWord(sampleWord),
    .sampleDataTag(sampleDataTag), .samplePaceTag(samplePaceTag),
    .paceValid(paceValid), .paceWord(paceWord), .paceIndex(paceIndex)
  );
endmodule

// File: rtl/ecg_burst_checker.sv
module ecg_burst_checker #(
  parameter int CHUNK_BYTES = 30,
  parameter int CNT_W       = 5,
  parameter int PIDX_W      = 5
) (
  input logic              clk,
  input logic              rstN,
  input logic              txStart,
  input logic [7:0]        txCmd,
  input logic [CNT_W-1:0]  txCount,
  input logic              sampleValid,
  input logic [2:0]        sampleDataTag,
  input logic              paceValid,
  input logic [PIDX_W-1:0] paceIndex,
  input logic              done
);
  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  assert_read_bit_R1: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> txCmd[0]);
  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    txStart |-> (txCount >= CNT_W'(2) && txCount <= CNT_W'(CHUNK_BYTES + 1)));
  assert_request_pulse_R3: assert property (@(posedge clk) disable iff (!rstN)
    txStart |=> !txStart);
  assert_no_empty_out_R6: assert property (@(posedge clk) disable iff (!rstN)
    sampleValid |-> sampleDataTag != 3'b110);
  assert_streams_apart_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(sampleValid && paceValid));
  assert_pace_index_R8: assert property (@(posedge clk) disable iff (!rstN)
    paceValid |-> paceIndex < PIDX_W'(18));
endmodule

bind ecg_burst_reader ecg_burst_checker #(
  .CHUNK_BYTES(CHUNK_BYTES), .CNT_W(CNT_W), .PIDX_W(PIDX_W)
) chkI (
  .clk(clk), .rstN(rstN), .txStart(txStart), .txCmd(txCmd),
  .txCount(txCount), .sampleValid(sampleValid), .sampleDataTag(sampleDataTag),
  .paceValid(paceValid), .paceIndex(paceIndex), .done(done)
);

// File: tb/ecg_burst_reader_tb_top.sv
`timescale 1ns/1ps
module ecg_burst_reader_tb_top;
  localparam int         FIT_W  = 5;
  localparam int         CHUNK  = 30;
  localparam logic [6:0] E_ADDR = 7'h20;
  localparam logic [6:0] P_ADDR = 7'h30;
  localparam int         P_STEP = 2;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [4:0]  fitCount = '0;
  logic        txStart;
  logic [7:0]  txCmd;
  logic [4:0]  txCount;
  logic        rxValid = 1'b0;
  logic [7:0]  rxByte = '0;
  logic        sampleValid;
  logic [23:0] sampleWord;
  logic [2:0]  sampleDataTag;
  logic [2:0]  samplePaceTag;
  logic        paceValid;
  logic [23:0] paceWord;
  logic [4:0]  paceIndex;
  logic        done;

  always #5 clk = ~clk;

  ecg_burst_reader #(
    .FIT_W(FIT_W), .CHUNK_BYTES(CHUNK), .ECG_ADDR(E_ADDR),
    .PACE_ADDR0(P_ADDR), .PACE_STEP(P_STEP)
  ) dut_i (
    .clk(clk), .rstN(rstN), .start(start), .fitCount(fitCount),
    .txStart(txStart), .txCmd(txCmd), .txCount(txCount),
    .rxValid(rxValid), .rxByte(rxByte), .sampleValid(sampleValid),
    .sampleWord(sampleWord), .sampleDataTag(sampleDataTag),
    .samplePaceTag(samplePaceTag), .paceValid(paceValid),
    .paceWord(paceWord), .paceIndex(paceIndex), .done(done)
  );

  int checks = 0;
  int errors = 0;
  int curFit, curMode;
  int expRem, ecgPos, nextGroup, txCnt, monIdx, paceCnt, doneCnt;
  int expN;
  logic [23:0] expWords[32];
  bit paceNeed;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] dtagOf(input int i);
    return (curMode == 2 && i % 3 == 1) ? 3'b110 : 3'b000;
  endfunction

  function automatic logic [2:0] ptagOf(input int i);
    if (curMode == 1) return (i == curFit) ? 3'b010 : 3'b111;
    if (curMode == 2) return (i % 2 == 0) ? 3'b001 : 3'b111;
    return 3'b111;
  endfunction

  function automatic logic [23:0] wordOf(input int i);
    return {8'(i * 7 + curFit), 8'(curMode * 40 + i), 2'b10, dtagOf(i), ptagOf(i)};
  endfunction

  function automatic logic [23:0] paceOf(input int g, input int k);
    return {8'(8'hC0 + g), 8'(k), 8'(g * 3 + k)};
  endfunction

  // transfer engine model
  initial begin
    forever begin
      @(negedge clk);
      while (txStart) begin
        automatic logic [7:0] cmd = txCmd;
        automatic int cnt = int'(txCount);
        automatic bit isEcg = (cmd[7:1] == E_ADDR);
        automatic int g = (int'(cmd[7:1]) - int'(P_ADDR)) / P_STEP;
        txCnt++;
        check(cmd[0] == 1'b1, "R1", "read bit", cmd[0], 1);
        if (isEcg) begin
          automatic int exp = (expRem > CHUNK) ? CHUNK : expRem;
          check(expRem > 0, "R3", "extra sample transfer", expRem, 1);
          check(cnt == exp + 1, "R3", "chunk count", cnt, exp + 1);
          expRem -= exp;
        end else begin
          check(paceNeed && expRem == 0, "R7", "pace transfer allowed", paceNeed, 1);
          check(g == nextGroup && cmd[7:1] == 7'(int'(P_ADDR) + g * P_STEP),
                "R7", "pace group address", cmd[7:1], int'(P_ADDR) + nextGroup * P_STEP);
          check(cnt == 10, "R7", "pace count", cnt, 10);
          nextGroup++;
        end
        for (int b = 0; b < cnt; b++) begin
          @(negedge clk);
          if (b % 4 == 2) begin
            rxValid = 1'b0;
            @(negedge clk);
          end
          rxValid = 1'b1;
          if (b == 0) rxByte = 8'hEE;
          else if (isEcg) begin
            automatic logic [23:0] w = wordOf(ecgPos / 3);
            rxByte = w[23 - 8 * (ecgPos % 3) -: 8];
            ecgPos++;
          end else begin
            automatic logic [23:0] w = paceOf(g, (b - 1) / 3);
            rxByte = w[23 - 8 * ((b - 1) % 3) -: 8];
          end
        end
        @(negedge clk);
        rxValid = 1'b0;
      end
    end
  end

  // output monitor
  initial begin
    forever begin
      @(negedge clk);
      if (rstN && sampleValid) begin
        if (monIdx < expN) begin
          check(sampleWord == expWords[monIdx], "R2", "sample word", sampleWord, expWords[monIdx]);
          check(sampleDataTag == expWords[monIdx][5:3] && samplePaceTag == expWords[monIdx][2:0],
                "R5", "tags", {sampleDataTag, samplePaceTag}, expWords[monIdx][5:0]);
        end else check(1'b0, "R6", "extra sample", monIdx, expN);
        monIdx++;
      end
      if (rstN && paceValid) begin
        check(paceWord == paceOf(paceCnt / 3, paceCnt % 3), "R8", "pace word",
              paceWord, paceOf(paceCnt / 3, paceCnt % 3));
        check(int'(paceIndex) == paceCnt, "R8", "pace index", paceIndex, paceCnt);
        paceCnt++;
      end
      if (rstN && done) doneCnt++;
    end
  end

  task automatic runBurst(input int fit, input int mode);
    automatic int chunks = ((fit + 1) * 3 + CHUNK - 1) / CHUNK;
    automatic int waitN = 0;
    automatic int txSnap;
    curFit = fit; curMode = mode;
    expN = 0; paceNeed = 0;
    for (int i = 0; i <= fit; i++) begin
      if (dtagOf(i) != 3'b110) begin
        expWords[expN] = wordOf(i);
        expN++;
      end
      if (ptagOf(i) != 3'b111) paceNeed = 1;
    end
    expRem = (fit + 1) * 3; ecgPos = 0; nextGroup = 0; txCnt = 0;
    monIdx = 0; paceCnt = 0; doneCnt = 0;
    @(negedge clk);
    fitCount = 5'(fit);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (4) @(negedge clk);
    start = 1'b1; // R10: ignored mid-burst
    @(negedge clk);
    start = 1'b0;
    while (doneCnt == 0 && waitN < 3000) begin
      @(negedge clk);
      waitN++;
    end
    check(doneCnt == 1, "R10", "done seen", doneCnt, 1);
    txSnap = txCnt;
    repeat (15) @(negedge clk);
    check(doneCnt == 1 && txCnt == txSnap, "R10", "no restart", txCnt, txSnap);
    check(monIdx == expN, "R6", "delivered words", monIdx, expN);
    check(expRem == 0 && ecgPos == (fit + 1) * 3, "R2", "bytes consumed", ecgPos, (fit + 1) * 3);
    if (paceNeed) begin
      check(nextGroup == 6 && paceCnt == 18, "R7", "pace sweep once", paceCnt, 18);
    end else begin
      check(nextGroup == 0 && paceCnt == 0, "R9", "no pace sweep", paceCnt, 0);
    end
    check(txCnt == chunks + (paceNeed ? 6 : 0), "R3", "transfer count", txCnt, chunks + (paceNeed ? 6 : 0));
    // R4: filler byte 8'hEE never appears inside a word; covered by word compares above
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!txStart && !done && !sampleValid && !paceValid, "R11", "reset outputs",
          {txStart, done, sampleValid, paceValid}, 0);
    rstN = 1'b1;
    @(negedge clk);
    check(!txStart && !done, "R11", "idle after reset", {txStart, done}, 0);
    for (int mode = 0; mode < 3; mode++)
      for (int fit = 0; fit < 32; fit++)
        runBurst(fit, mode);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule